// File: doc/BRIEF.md
# JESD204B Transport Sample Packer (four converters on eight lanes)

This block sits between a sample source and the lane interface of a JESD204B transmitter. It takes groups of four 16-bit converter samples, one group per frame, and arranges them as eight 32-bit lane words. The arrangement has four converters and one sample per converter per frame, carried on eight lanes with one octet per lane per frame. Each converter's sample is split across a pair of neighbouring lanes. Four successive frames are gathered into each lane word, so the lane side updates at one quarter of the sample-group rate.

While the transmit path is enabled, every clock cycle is a frame slot and a sample group is expected in it. A missing group would leave the converter's elastic buffer empty. The packer therefore puts zeros in that slot and raises a sticky underrun flag. A multiframe tracker counts emitted lane words against a configurable frame count K and marks the word that closes each multiframe. Scrambling, line coding, lane alignment sequences and link synchronisation are handled elsewhere.

Top module: `jesd_sample_packer`

## Requirements
- R1: `in_ready` is high exactly while `tx_enable` is high. A sample group is taken in a cycle where both `tx_enable` and `in_valid` are high.
- R2: For converter c (c = 0..3, carried in `in_samples[16c+15:16c]`), the high octet `[15:8]` goes to lane 2c and the low octet `[7:0]` goes to lane 2c+1. Lane l occupies `lane_data[32l+31:32l]`.
- R3: Within a lane word, the octet of the first frame slot sits in bits `[31:24]`, the second in `[23:16]`, the third in `[15:8]` and the fourth in `[7:0]`.
- R4: `lane_valid` is high for exactly one cycle, the cycle after every fourth frame slot, and `lane_data` carries the newly completed words in that cycle. `lane_valid` is low at all other times.
- R5: Every cycle with `tx_enable` high is a frame slot. If `in_valid` is low in a slot, zero octets are placed for all four converters and `underrun` goes high in the next cycle. It then stays high until reset.
- R6: While `tx_enable` is low there is no frame slot. The position within the lane word is held, `in_valid` is ignored, `underrun` is not set and no lane word is emitted.
- R7: `mf_end` is high together with `lane_valid` on every (K/4)-th lane word counted since reset, where K is `k_frames`. It is low at all other times.
- R8: The two low bits of `k_frames` are ignored. A value of K/4 equal to zero is treated as one lane word per multiframe.
- R9: A synchronous active-low reset clears `lane_valid`, `mf_end`, `underrun`, `lane_data`, the frame position and the multiframe position. The first slot after reset lands in bits `[31:24]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Frame-slot clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_enable | input | 1 | Transmit enable; each cycle it is high is one frame slot |
| in_valid | input | 1 | Sample group present |
| in_ready | output | 1 | Sample group taken when `in_valid` is also high |
| in_samples | input | 64 | Four 16-bit samples, converter 0 in the low 16 bits |
| k_frames | input | 6 | Frames per multiframe (K), expected to be a multiple of 4 |
| lane_valid | output | 1 | One-cycle strobe for new lane words |
| lane_data | output | 256 | Eight 32-bit lane words, lane 0 in the low 32 bits |
| mf_end | output | 1 | The emitted words close a multiframe |
| underrun | output | 1 | Sticky flag: a frame slot passed without a sample group |

## Verification
The zero fill on a missing sample and the multiframe end marker can act in the same cycle. This happens when the missing group falls in the last slot of the lane word that closes a multiframe. The bench provokes it by dropping `in_valid` on the fourth slot of the second word of an eight-frame multiframe. It then judges the following cycle: `lane_valid`, `mf_end` and `underrun` must all be high at once, and the low octet of every lane word must be zero while the upper three octets still hold the accepted samples. A second case drops the first slot of a later closing word, which zeroes the top octet instead.

// File: rtl/jsp_pkg.sv
// Package jsp_pkg
// Shared sizes and the frame-slot type of the 8-4-1-1 transport packer.
// Assumes octet-aligned samples and an integer number of frames per lane word.
package jsp_pkg;
    localparam int SAMP_W        = 16;
    localparam int OCT_W         = 8;
    localparam int N_CONV        = 4;
    localparam int OCT_PER_SAMP  = SAMP_W / OCT_W;
    localparam int N_LANE        = N_CONV * OCT_PER_SAMP;
    localparam int FRM_PER_WORD  = 4;
    localparam int LANE_W        = OCT_W * FRM_PER_WORD;
    localparam int FCNT_W        = $clog2(FRM_PER_WORD);
    localparam int KW            = 6;

    // Kind of the current frame slot
    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,
        SLOT_DATA = 2'd1,
        SLOT_FILL = 2'd2
    } slot_kind_e;
endpackage

// File: rtl/jsp_frame_ctrl.sv
// Module jsp_frame_ctrl
// Classifies each cycle as an idle, data or fill slot and tracks the frame
// position inside a lane word. Raises word_done on the last slot of a word
// and keeps a sticky underrun flag.
// Assumes: every cycle with en high is one frame slot.
module jsp_frame_ctrl
    import jsp_pkg::*;
#(
    parameter int FPW = FRM_PER_WORD
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       in_valid,
    output logic       in_ready,
    output slot_kind_e slot_kind,
    output logic       word_done,
    output logic       underrun
);
    localparam int CW = $clog2(FPW);
    localparam logic [CW-1:0] LAST_POS = CW'(FPW - 1);

    logic [CW-1:0] fcnt;

    // Slot classification and handshake
    always_comb begin
        in_ready = en;
        if (!en)
            slot_kind = SLOT_IDLE;
        else if (in_valid)
            slot_kind = SLOT_DATA;
        else
            slot_kind = SLOT_FILL;
        word_done = (slot_kind != SLOT_IDLE) && (fcnt == LAST_POS);
    end

    // Frame position within the lane word
    always_ff @(posedge clk) begin
        if (!rst_n)
            fcnt <= '0;
        else if (slot_kind != SLOT_IDLE)
            fcnt <= (fcnt == LAST_POS) ? '0 : fcnt + 1'b1;
    end

    // Sticky underrun flag
    always_ff @(posedge clk) begin
        if (!rst_n)
            underrun <= 1'b0;
        else if (slot_kind == SLOT_FILL)
            underrun <= 1'b1;
    end

    assert_hold_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(fcnt));
    assert_fill_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !in_valid) |=> underrun);
    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);
endmodule

// File: rtl/jsp_lane_map.sv
// Module jsp_lane_map
// Splits each converter sample into high and low octets on neighbouring
// lanes and shifts successive frame octets into a per-lane accumulator.
// The earliest frame ends up in the top octet of the lane word.
// Assumes word_done marks the last slot of each word.
module jsp_lane_map
    import jsp_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  slot_kind_e               slot_kind,
    input  logic                     word_done,
    input  logic [N_CONV*SAMP_W-1:0] samples,
    output logic [N_LANE*LANE_W-1:0] lane_words,
    output logic                     lane_valid
);
    localparam int ACC_W = LANE_W - OCT_W;

    for (genvar l = 0; l < N_LANE; l++) begin : g_lane
        localparam int CONV = l / OCT_PER_SAMP;
        localparam int PART = l % OCT_PER_SAMP;
        localparam int MSB  = CONV * SAMP_W + SAMP_W - 1 - PART * OCT_W;

        logic [OCT_W-1:0]  oct;
        logic [ACC_W-1:0]  acc;
        logic [LANE_W-1:0] word;

        // Octet selected for this lane, zero in a fill slot
        always_comb oct = (slot_kind == SLOT_DATA) ? samples[MSB -: OCT_W] : '0;

        // Accumulate frames and close the word on the last slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc  <= '0;
                word <= '0;
            end else if (slot_kind != SLOT_IDLE) begin
                if (word_done) begin
                    word <= {acc, oct};
                    acc  <= '0;
                end else begin
                    acc  <= ACC_W'({acc, oct});
                end
            end
        end

        assign lane_words[l*LANE_W +: LANE_W] = word;
    end

    // Output strobe, one cycle per completed word
    always_ff @(posedge clk) begin
        if (!rst_n)
            lane_valid <= 1'b0;
        else
            lane_valid <= word_done;
    end

    assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lane_valid |=> !lane_valid);
    assert_words_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !word_done |=> $stable(lane_words));
endmodule

// File: rtl/jsp_mf_track.sv
// Module jsp_mf_track
// Counts emitted lane words against K/4 words per multiframe and marks the
// word that closes each multiframe.
// Assumes K is a multiple of the frames per word; the low bits are dropped.
module jsp_mf_track
    import jsp_pkg::*;
#(
    parameter int KBITS = KW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             word_done,
    input  logic [KBITS-1:0] k_frames,
    output logic             mf_end
);
    logic [KBITS-1:0] words_per_mf;
    logic [KBITS-1:0] last_idx;
    logic [KBITS-1:0] wcnt;
    logic             at_last;

    // Multiframe length in words and the final word index
    always_comb begin
        words_per_mf = k_frames >> FCNT_W;
        last_idx     = (words_per_mf == '0) ? '0 : words_per_mf - 1'b1;
        at_last      = (wcnt >= last_idx);
    end

    // Word counter and end-of-multiframe marker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt   <= '0;
            mf_end <= 1'b0;
        end else if (word_done) begin
            wcnt   <= at_last ? '0 : wcnt + 1'b1;
            mf_end <= at_last;
        end else begin
            mf_end <= 1'b0;
        end
    end

    assert_mf_from_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mf_end |-> $past(word_done));
endmodule

// File: rtl/jesd_sample_packer.sv
// Module jesd_sample_packer
// Top level of the 8-4-1-1 transport packer: frame control, lane mapping
// and multiframe tracking.
// Assumes every enabled cycle is one frame slot and K is a multiple of four.
module jesd_sample_packer
    import jsp_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tx_enable,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [N_CONV*SAMP_W-1:0] in_samples,
    input  logic [KW-1:0]            k_frames,
    output logic                     lane_valid,
    output logic [N_LANE*LANE_W-1:0] lane_data,
    output logic                     mf_end,
    output logic                     underrun
);
    slot_kind_e slot_kind;
    logic       word_done;

    jsp_frame_ctrl #(.FPW(FRM_PER_WORD)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (tx_enable),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .slot_kind (slot_kind),
        .word_done (word_done),
        .underrun  (underrun)
    );

    jsp_lane_map u_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_kind  (slot_kind),
        .word_done  (word_done),
        .samples    (in_samples),
        .lane_words (lane_data),
        .lane_valid (lane_valid)
    );

    jsp_mf_track #(.KBITS(KW)) u_mf (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_done (word_done),
        .k_frames  (k_frames),
        .mf_end    (mf_end)
    );

    assert_mf_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mf_end |-> lane_valid);
endmodule

// File: tb/jesd_sample_packer_test.sv
`timescale 1ns/1ps
module jesd_sample_packer_test;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         tx_enable;
    logic         in_valid;
    logic         in_ready;
    logic [63:0]  in_samples;
    logic [5:0]   k_frames;
    logic         lane_valid;
    logic [255:0] lane_data;
    logic         mf_end;
    logic         underrun;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    jesd_sample_packer uut (
        .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .in_valid(in_valid),
        .in_ready(in_ready), .in_samples(in_samples), .k_frames(k_frames),
        .lane_valid(lane_valid), .lane_data(lane_data), .mf_end(mf_end),
        .underrun(underrun)
    );

    // Stimulus table: four frames per entry {f3,f2,f1,f0}, with lane 0 and lane 7 words
    localparam logic [3:0][63:0] VEC [4] = '{
        {64'hD6D7_C6C7_B6B7_A6A7, 64'hD4D5_C4C5_B4B5_A4A5,
         64'hD2D3_C2C3_B2B3_A2A3, 64'hD0D1_C0C1_B0B1_A0A1},
        {64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF,
         64'h0000_0000_0000_0000, 64'h8001_4002_2004_1008},
        {64'hDDDD_EEEE_FFFF_0000, 64'h9999_AAAA_BBBB_CCCC,
         64'h5555_6666_7777_8888, 64'h1111_2222_3333_4444},
        {64'h7FFF_8000_0001_FFFE, 64'h1234_5678_9ABC_DEF0,
         64'h0F0F_F0F0_AA55_55AA, 64'hDEAD_BEEF_CAFE_F00D}
    };
    localparam logic [31:0] EXP_L0 [4] = '{32'hA0A2A4A6, 32'h1000FFCD, 32'h4488CC00, 32'hF055DEFF};
    localparam logic [31:0] EXP_L7 [4] = '{32'hD1D3D5D7, 32'h0100FF23, 32'h115599DD, 32'hAD0F34FF};

    task automatic cmp(input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Expected lane words from the mapping rules (R2, R3, R5 zero fill)
    function automatic logic [255:0] model(input logic [3:0][63:0] g, input logic [3:0] v);
        logic [255:0] r = '0;
        for (int l = 0; l < 8; l++) begin
            logic [31:0] w = '0;
            int c = l / 2;
            for (int f = 0; f < 4; f++) begin
                logic [7:0] o;
                if (!v[f])          o = 8'h00;
                else if (l % 2 == 0) o = g[f][16*c+15 -: 8];
                else                o = g[f][16*c+7 -: 8];
                w = {w[23:0], o};
            end
            r[32*l +: 32] = w;
        end
        return r;
    endfunction

    task automatic push(input logic [63:0] s, input bit v);
        tx_enable  = 1'b1;
        in_valid   = v;
        in_samples = s;
        @(posedge clk);
        @(negedge clk);
    endtask

    // One lane word; optional disabled cycles after the second frame
    task automatic run_word(input logic [3:0][63:0] g, input logic [3:0] v,
                            input int idle, input bit exp_mf, input string tag);
        bit early = 1'b0;
        bit idle_bad = 1'b0;
        for (int f = 0; f < 4; f++) begin
            push(g[f], v[f]);
            if (f < 3 && lane_valid) early = 1'b1;
            if (f == 1 && idle > 0) begin
                tx_enable = 1'b0;
                in_valid  = 1'b1;
                for (int i = 0; i < idle; i++) begin
                    #1;
                    if (in_ready) idle_bad = 1'b1;
                    @(posedge clk);
                    @(negedge clk);
                    if (lane_valid || underrun || mf_end) idle_bad = 1'b1;
                end
            end
        end
        if (idle > 0) cmp({"R6 disabled cycles quiet ", tag}, {255'd0, idle_bad}, 256'd0);
        cmp({"R4 no early strobe ", tag}, {255'd0, early}, 256'd0);
        cmp({"R4 strobe after fourth slot ", tag}, {255'd0, lane_valid}, 256'd1);
        cmp({"R2 R3 lane words ", tag}, lane_data, model(g, v));
        cmp({"R7 multiframe marker ", tag}, {255'd0, mf_end}, {255'd0, exp_mf});
        tx_enable = 1'b0;
        in_valid  = 1'b0;
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog act=timeout exp=completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; tx_enable = 1'b0; in_valid = 1'b0; in_samples = '0; k_frames = 6'd8;
        repeat (2) @(posedge clk);
        @(negedge clk);
        cmp("R9 reset state", {lane_data, 4'b0} >> 4 | {252'd0, lane_valid, mf_end, underrun, 1'b0},
            256'd0);
        rst_n = 1'b1;

        // R1 handshake follows the enable
        #1;
        cmp("R1 ready low when disabled", {255'd0, in_ready}, 256'd0);
        tx_enable = 1'b1; #1;
        cmp("R1 ready high when enabled", {255'd0, in_ready}, 256'd1);
        tx_enable = 1'b0;
        @(negedge clk);

        // Table walk, K = 8 gives a marker on every second word
        for (int e = 0; e < 4; e++) begin
            run_word(VEC[e], 4'b1111, 0, (e % 2) == 1, $sformatf("vec%0d", e));
            cmp($sformatf("R2 R3 lane0 vec%0d", e), {224'd0, lane_data[31:0]},  {224'd0, EXP_L0[e]});
            cmp($sformatf("R2 R3 lane7 vec%0d", e), {224'd0, lane_data[255:224]}, {224'd0, EXP_L7[e]});
        end
        cmp("R5 no underrun with full input", {255'd0, underrun}, 256'd0);

        // R6: enable dropped mid-word, in_valid high meanwhile
        run_word(VEC[2], 4'b1111, 5, 1'b0, "pause word4");
        cmp("R5 R6 no underrun after pause", {255'd0, underrun}, 256'd0);

        // R5 with R7: missing group in last slot of multiframe-closing word
        run_word(VEC[3], 4'b0111, 0, 1'b1, "fill last slot word5");
        cmp("R5 underrun with marker", {255'd0, underrun}, 256'd1);

        // R5 sticky over a full word
        run_word(VEC[0], 4'b1111, 0, 1'b0, "word6");
        cmp("R5 underrun sticky", {255'd0, underrun}, 256'd1);

        // Missing group in the first slot zeroes the top octet
        run_word(VEC[1], 4'b1110, 0, 1'b1, "fill first slot word7");

        // R9: reset in mid-word
        push(VEC[3][0], 1'b1);
        push(VEC[3][1], 1'b1);
        rst_n = 1'b0; tx_enable = 1'b0; in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        cmp("R9 reset clears flags", {252'd0, lane_valid, mf_end, underrun, 1'b0}, 256'd0);
        cmp("R9 reset clears lane data", lane_data, 256'd0);
        rst_n = 1'b1;

        // R8: K = 0 -> one word per multiframe; first sample after reset at top (R9)
        k_frames = 6'd0;
        run_word(VEC[2], 4'b1111, 0, 1'b1, "R9 R8 k0 after reset");
        k_frames = 6'd5;
        run_word(VEC[1], 4'b1111, 0, 1'b1, "R8 k5 low bits ignored");
        k_frames = 6'd12;
        run_word(VEC[0], 4'b1111, 0, 1'b0, "R7 k12 w0");
        run_word(VEC[3], 4'b1111, 0, 1'b0, "R7 k12 w1");
        run_word(VEC[2], 4'b1111, 0, 1'b1, "R7 k12 w2");

        @(negedge clk);
        cmp("R4 strobe cleared when idle", {255'd0, lane_valid}, 256'd0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule